// File: doc/BRIEF.md
# Address Tenure Master Controller

This block runs the address phase of a split-transaction processor bus on behalf of one bus master. An internal requester presents an address and a 5-bit transfer type and holds them. The block waits for a bus grant that arrives while the address bus is idle. It then drives a one-clock start strobe, presents the address and transfer type, and holds bus-busy until the address acknowledge is sampled. In the following cycle it releases every tri-statable signal.

Other masters may also own the bus. Their ownership is tracked from the external bus-busy pin and from a local tracker. The tracker is set by another master's start strobe and cleared by an address acknowledge. A start strobe seen from another master also raises a snoop-valid pulse in that cycle. When the start strobe is driven, a data-bus request goes out alongside it if the latched transfer type needs a data tenure. That decision comes from a parameter lookup table that has one bit per transfer-type value.

All bus signals are active-high inside the block. Each tri-statable bus signal has its own value output and its own enable output.

Top module: `addr_tenure_master`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, start_o, busy_o, dbr_o, every enable output and addr_o/tt_o are all zero.
- R2: A grant is accepted only in a cycle where req_valid_i, bg_i are high, bus_busy_i is low and the local tracker is clear, with no tenure in progress; req_accept_o is high exactly in that cycle and any grant not meeting these conditions has no effect on the outputs.
- R3: start_o and start_oe_o rise in the cycle after acceptance, and start_o stays high for exactly one clock.
- R4: busy_o and busy_oe_o rise together with start_o and stay high until the address acknowledge has been sampled; after the first cycle, start_o is driven low with start_oe_o held high.
- R5: In the cycle after aack_i is sampled high during the block's own tenure, start_oe_o, busy_oe_o and attr_oe_o are low, and busy_o is low.
- R6: While attr_oe_o is high, addr_o and tt_o hold the address and type latched at acceptance; while it is low they read zero.
- R7: dbr_o is high in the start cycle exactly when bit tt of DATA_TT_MASK is set (bit index = tt_o value); with the default mask, types with tt[4]=0 need a data tenure; dbr_o is low in every other cycle.
- R8: The local tracker is set at a clock where ts_in_i is high and cleared at a clock where aack_i is high alone; when both are high, set wins. While it is set, grants are refused.
- R9: snoop_valid_o equals ts_in_i in any cycle where the block is not driving the start signal, and is low while it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request pending, held until accepted |
| req_addr_i | input | ADDR_W | Requested address |
| req_tt_i | input | TT_W | Requested transfer type |
| req_accept_o | output | 1 | Grant accepted this cycle; request latched |
| bg_i | input | 1 | Bus grant |
| bus_busy_i | input | 1 | External bus-busy pin, another master owns the bus |
| ts_in_i | input | 1 | Start strobe observed from another master |
| aack_i | input | 1 | Address acknowledge |
| start_o | output | 1 | Start strobe value |
| start_oe_o | output | 1 | Start strobe drive enable |
| busy_o | output | 1 | Bus-busy value |
| busy_oe_o | output | 1 | Bus-busy drive enable |
| addr_o | output | ADDR_W | Address value |
| tt_o | output | TT_W | Transfer type value |
| attr_oe_o | output | 1 | Address and type drive enable |
| dbr_o | output | 1 | Implied data-bus request |
| snoop_valid_o | output | 1 | Another master's address is valid for snooping |

## Verification
The bench builds two copies of the block with ADDR_W=16 and TT_W=5. The first uses the default mask. The second uses the irregular mask 32'h3C3C_A5A5. Together they let every one of the 32 transfer types be swept through a full tenure against both mask shapes, and the expected data request for each is computed from the mask bit. The same small configuration makes it practical to sweep all 16 combinations of request, grant, busy pin and tracker state. Acknowledge delays of zero to three cycles are also covered, as is the case where an acknowledge and another master's start strobe land in the same cycle.

// File: rtl/atm_pkg.sv
package atm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_START  = 2'd1,
    ST_TENURE = 2'd2
  } tenure_state_e;
endpackage

// File: rtl/atm_busy_tracker.sv
module atm_busy_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ts_in_i,
  input  logic aack_i,
  output logic busy_o
);
  logic busy_q;

  // a new tenure starting on the same edge as an old one ends wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (ts_in_i) busy_q <= 1'b1;
    else if (aack_i)  busy_q <= 1'b0;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/atm_tt_decode.sv
module atm_tt_decode #(
  parameter int unsigned          TT_W = 5,
  parameter logic [(1<<TT_W)-1:0] MASK = '0
) (
  input  logic [TT_W-1:0] tt_i,
  output logic            data_o
);
  localparam int unsigned N_TT = 1 << TT_W;

  logic [N_TT-1:0] lut;

  for (genvar i = 0; i < N_TT; i++) begin : g_lut
    assign lut[i] = MASK[i];
  end

  assign data_o = lut[tt_i];
endmodule

// File: rtl/atm_tenure_fsm.sv
module atm_tenure_fsm
  import atm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TT_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_ok_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [TT_W-1:0]   req_tt_i,
  input  logic              aack_i,
  output logic              start_o,
  output logic              drive_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [TT_W-1:0]   tt_o
);
  tenure_state_e     state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [TT_W-1:0]   tt_q;
  logic              accept;

  assign accept = (state_q == ST_IDLE) && grant_ok_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (grant_ok_i) state_d = ST_START;
      ST_START:  state_d = aack_i ? ST_IDLE : ST_TENURE;
      ST_TENURE: if (aack_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      tt_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= req_addr_i;
        tt_q   <= req_tt_i;
      end
    end
  end

  assign start_o = (state_q == ST_START);
  assign drive_o = (state_q != ST_IDLE);
  assign addr_o  = drive_o ? addr_q : '0;
  assign tt_o    = drive_o ? tt_q : '0;
endmodule

// File: rtl/addr_tenure_master.sv
module addr_tenure_master #(
  parameter int unsigned          ADDR_W       = 32,
  parameter int unsigned          TT_W         = 5,
  parameter logic [(1<<TT_W)-1:0] DATA_TT_MASK = 32'h0000_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [TT_W-1:0]   req_tt_i,
  output logic              req_accept_o,
  input  logic              bg_i,
  input  logic              bus_busy_i,
  input  logic              ts_in_i,
  input  logic              aack_i,
  output logic              start_o,
  output logic              start_oe_o,
  output logic              busy_o,
  output logic              busy_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [TT_W-1:0]   tt_o,
  output logic              attr_oe_o,
  output logic              dbr_o,
  output logic              snoop_valid_o
);
  logic trk_busy;
  logic grant_ok;
  logic drive;
  logic strobe;
  logic needs_data;

  atm_busy_tracker u_trk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ts_in_i (ts_in_i),
    .aack_i  (aack_i),
    .busy_o  (trk_busy)
  );

  // qualified grant: pin and tracker both idle, request pending
  assign grant_ok = req_valid_i && bg_i && !bus_busy_i && !trk_busy;

  atm_tenure_fsm #(
    .ADDR_W (ADDR_W),
    .TT_W   (TT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_ok_i (grant_ok),
    .req_addr_i (req_addr_i),
    .req_tt_i   (req_tt_i),
    .aack_i     (aack_i),
    .start_o    (strobe),
    .drive_o    (drive),
    .addr_o     (addr_o),
    .tt_o       (tt_o)
  );

  atm_tt_decode #(
    .TT_W (TT_W),
    .MASK (DATA_TT_MASK)
  ) u_dec (
    .tt_i   (tt_o),
    .data_o (needs_data)
  );

  assign req_accept_o  = grant_ok && !drive;
  assign start_o       = strobe;
  assign start_oe_o    = drive;
  assign busy_o        = drive;
  assign busy_oe_o     = drive;
  assign attr_oe_o     = drive;
  assign dbr_o         = strobe && needs_data;
  assign snoop_valid_o = ts_in_i && !drive;
endmodule

// File: rtl/atm_checker.sv
module atm_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TT_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              bg_i,
  input logic              bus_busy_i,
  input logic              ts_in_i,
  input logic              aack_i,
  input logic              start_o,
  input logic              start_oe_o,
  input logic              busy_o,
  input logic              busy_oe_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              attr_oe_o,
  input logic              dbr_o,
  input logic              snoop_valid_o
);
  assert_grant_qualified_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> $past(req_valid_i && bg_i && !bus_busy_i));

  assert_start_one_clock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  assert_start_with_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (busy_o && busy_oe_o && start_oe_o && attr_oe_o));

  assert_busy_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_oe_o && !aack_i) |=> (busy_o && busy_oe_o));

  assert_release_after_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_oe_o && aack_i) |=> (!busy_oe_o && !start_oe_o && !attr_oe_o && !busy_o));

  assert_addr_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attr_oe_o && $past(attr_oe_o)) |-> $stable(addr_o));

  assert_dbr_only_on_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbr_o |-> start_o);

  assert_snoop_from_pin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_valid_o |-> (ts_in_i && !start_oe_o));
endmodule

bind addr_tenure_master atm_checker #(
  .ADDR_W (ADDR_W),
  .TT_W   (TT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .bg_i          (bg_i),
  .bus_busy_i    (bus_busy_i),
  .ts_in_i       (ts_in_i),
  .aack_i        (aack_i),
  .start_o       (start_o),
  .start_oe_o    (start_oe_o),
  .busy_o        (busy_o),
  .busy_oe_o     (busy_oe_o),
  .addr_o        (addr_o),
  .attr_oe_o     (attr_oe_o),
  .dbr_o         (dbr_o),
  .snoop_valid_o (snoop_valid_o)
);

// File: tb/addr_tenure_master_tb.sv
`timescale 1ns/1ps
module addr_tenure_master_tb;
  localparam int unsigned AW       = 16;
  localparam int unsigned TW       = 5;
  localparam logic [31:0] MASK_DEF = 32'h0000_FFFF;
  localparam logic [31:0] MASK_ALT = 32'h3C3C_A5A5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, bg = 1'b0, bbusy = 1'b0, ts_in = 1'b0, aack = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_tt = '0;

  logic acc, st, st_oe, bsy, bsy_oe, a_oe, dbr, snp;
  logic [AW-1:0] addr;
  logic [TW-1:0] tt;
  logic acc2, st2, st_oe2, bsy2, bsy_oe2, a_oe2, dbr2, snp2;
  logic [AW-1:0] addr2;
  logic [TW-1:0] tt2;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_tenure_master #(.ADDR_W(AW), .TT_W(TW), .DATA_TT_MASK(MASK_DEF)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_tt_i(req_tt), .req_accept_o(acc), .bg_i(bg), .bus_busy_i(bbusy),
    .ts_in_i(ts_in), .aack_i(aack), .start_o(st), .start_oe_o(st_oe), .busy_o(bsy),
    .busy_oe_o(bsy_oe), .addr_o(addr), .tt_o(tt), .attr_oe_o(a_oe), .dbr_o(dbr),
    .snoop_valid_o(snp));

  addr_tenure_master #(.ADDR_W(AW), .TT_W(TW), .DATA_TT_MASK(MASK_ALT)) u_dut_alt (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_tt_i(req_tt), .req_accept_o(acc2), .bg_i(bg), .bus_busy_i(bbusy),
    .ts_in_i(ts_in), .aack_i(aack), .start_o(st2), .start_oe_o(st_oe2), .busy_o(bsy2),
    .busy_oe_o(bsy_oe2), .addr_o(addr2), .tt_o(tt2), .attr_oe_o(a_oe2), .dbr_o(dbr2),
    .snoop_valid_o(snp2));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // idle outputs of the main instance
  task automatic chk_idle(input string req);
    chk(req, {st, st_oe, bsy, bsy_oe, a_oe, dbr}, 32'h0);
    chk(req, {addr, 3'b0, tt}, 32'h0);
  endtask

  // full own tenure; grant offered with inputs already idle
  task automatic tenure(input logic [TW-1:0] t, input logic [AW-1:0] a, input int dly);
    req_valid = 1'b1; req_tt = t; req_addr = a; bg = 1'b1;
    #1 chk("R2 accept", acc, 1'b1);
    tick();
    req_valid = 1'b0; bg = 1'b0; req_tt = ~t; req_addr = ~a;
    chk("R3 start", {st, st_oe}, 2'b11);
    chk("R4 busy with start", {bsy, bsy_oe, a_oe}, 3'b111);
    chk("R6 addr", addr, a);
    chk("R6 tt", tt, t);
    chk("R7 dbr default mask", dbr, MASK_DEF[t]);
    chk("R7 dbr alt mask", dbr2, MASK_ALT[t]);
    if (dly == 0) aack = 1'b1;
    for (int k = 1; k <= dly; k++) begin
      tick();
      chk("R3 start one clock", {st, st_oe}, 2'b01);
      chk("R4 busy held", {bsy, bsy_oe, a_oe, dbr}, 4'b1110);
      chk("R6 addr held", addr, a);
      if (k == dly) aack = 1'b1;
    end
    tick();
    aack = 1'b0;
    chk("R5 release", {st_oe, bsy_oe, a_oe, bsy}, 4'b0000);
    chk("R6 attr zero idle", {addr, 3'b0, tt}, 32'h0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset
    bg = 1'b1; req_valid = 1'b1;
    repeat (3) tick();
    chk_idle("R1 in reset");
    chk("R1 in reset alt", {st2, st_oe2, bsy2, dbr2}, 4'h0);
    bg = 1'b0; req_valid = 1'b0;
    rst_ni = 1'b1;
    tick();
    chk_idle("R1 after reset");

    // R7 sweep over all types, both masks, varying ack delay
    for (int t = 0; t < 32; t++) begin
      tenure(TW'(t), AW'(16'h1000 + t * 16'h0111), t % 4);
      tick();
    end

    // R2/R8 sweep: req, bg, pin, tracker
    for (int c = 0; c < 16; c++) begin
      logic r, g, b, k, exp;
      {k, b, g, r} = 4'(c);
      exp = r & g & ~b & ~k;
      if (k) begin
        ts_in = 1'b1;
        #1 chk("R9 snoop pulse", snp, 1'b1);
        tick();
        ts_in = 1'b0;
        #1 chk("R9 snoop idle", snp, 1'b0);
      end
      req_valid = r; bg = g; bbusy = b; req_addr = AW'(c); req_tt = TW'(c);
      #1 chk("R2 accept qualify", acc, exp);
      tick();
      req_valid = 1'b0; bg = 1'b0; bbusy = 1'b0;
      chk("R2 start only when qualified", st, exp);
      chk("R8 tracker gate", bsy_oe, exp);
      aack = 1'b1;
      tick();
      aack = 1'b0;
      chk("R5 release sweep", {st_oe, bsy_oe, bsy}, 3'b000);
      tick();
    end

    // R8: ts and aack on the same edge: set wins
    ts_in = 1'b1; aack = 1'b1;
    tick();
    ts_in = 1'b0; aack = 1'b0;
    req_valid = 1'b1; bg = 1'b1;
    #1 chk("R8 set wins", acc, 1'b0);
    tick();
    chk("R8 no start when tracked", st_oe, 1'b0);
    req_valid = 1'b0; bg = 1'b0;
    aack = 1'b1;
    tick();
    aack = 1'b0;
    req_valid = 1'b1; bg = 1'b1;
    #1 chk("R8 cleared by ack", acc, 1'b1);
    req_valid = 1'b0; bg = 1'b0;
    tick();

    // R9: foreign start strobe while this block drives start_o
    req_valid = 1'b1; bg = 1'b1; req_tt = 5'h10; req_addr = 16'hBEEF;
    tick();
    req_valid = 1'b0; bg = 1'b0; ts_in = 1'b1;
    #1 chk("R9 no snoop while driving", snp, 1'b0);
    chk("R7 no dbr tt msb set", dbr, 1'b0);
    tick();
    ts_in = 1'b0; aack = 1'b1;
    tick();
    aack = 1'b0;
    chk("R5 release final", {st_oe, bsy_oe, a_oe}, 3'b000);
    tick();
    ts_in = 1'b1;
    #1 chk("R9 snoop when idle", snp, 1'b1);
    ts_in = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule